// File: doc/BRIEF.md
# Unsigned Reciprocal Divider for a Fixed Divisor

This block computes floor quotients of unsigned WIDTH-bit dividends by a single divisor that is loaded rarely and then reused for many dividends. No quotient is produced by iteration. A one-time setup step turns the divisor into a multiplier and two shift amounts. After that, each dividend costs one multiply-high, one subtract, one add and two logical shifts, spread over a two-stage pipeline.

Setup starts with a single-cycle request on the configuration port. For divisors of three and above, a bit-serial restoring divider forms the multiplier in WIDTH cycles, and a busy flag is raised for that time. Divisors one and two need no division and finish immediately. Every setup ends with a one-cycle done pulse. A zero divisor ends with an error flag and produces no usable parameters. Dividends enter through a valid/ready port and quotients leave through a valid/ready port that holds its data while the consumer stalls. WIDTH may be 8, 16 or 32, among other values.

Top module: `recip_divider`

## Requirements
- R1: After reset, cfg_busy, cfg_done, cfg_err and out_valid are low, and in_ready is low until a setup has completed.
- R2: A setup request taken while idle with a divisor d of 3 or more holds cfg_busy high for exactly WIDTH cycles and then pulses cfg_done for one cycle. For d equal to 1 or 2, cfg_done pulses in the cycle after the request and cfg_busy stays low. in_ready is low whenever cfg_busy is high.
- R3: With d = 1, every quotient equals its dividend, including 0 and 2^WIDTH−1.
- R4: With d = 2, every quotient equals the dividend shifted right by one.
- R5: For any d of 3 or more, each quotient equals floor(a/d). This includes powers of two and d = 2^WIDTH−1, where the intermediate power 2^ceil(log2 d) wraps to zero.
- R6: A zero divisor sets cfg_err and pulses cfg_done. in_ready then stays low, so no dividend is accepted, until a later setup with a nonzero divisor clears cfg_err.
- R7: A dividend accepted at a clock edge, with the pipeline free, appears on out_valid/out_quotient two edges later. Quotients leave in the order their dividends were accepted.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_quotient does not change.
- R9: A setup request made while cfg_busy is high is ignored. The running setup completes with its own divisor, and no second setup follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | One-cycle setup request |
| cfg_divisor | input | WIDTH | Divisor taken with the request |
| cfg_busy | output | 1 | Multiplier computation in progress |
| cfg_done | output | 1 | One-cycle pulse when a setup ends |
| cfg_err | output | 1 | Last setup had a zero divisor |
| in_valid | input | 1 | Dividend present |
| in_ready | output | 1 | Dividend will be accepted |
| in_dividend | input | WIDTH | Unsigned dividend |
| out_valid | output | 1 | Quotient present |
| out_ready | input | 1 | Consumer takes the quotient |
| out_quotient | output | WIDTH | floor(dividend / divisor) |

## Verification
The properties assume the producer keeps in_valid and in_dividend steady until in_ready accepts them. They also assume setup requests last one cycle and are not raised while dividends are still queued for a divisor that is about to change. The stimulus drives inputs just after the rising edge and releases in_valid only after a negative-edge sample has seen in_ready. It drains all outstanding quotients before each new setup, except in the one case where a second request is placed on purpose inside an active busy window. With the consumer stalled, the stimulus only fills the two pipeline stages and then releases the stall.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [0:0] {
      CFG_IDLE = 1'b0,
      CFG_CALC = 1'b1
   } cfg_state_e;
endpackage

// File: rtl/recip_param_gen.sv
module recip_param_gen
   import recip_div_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_valid,
   input  logic [WIDTH-1:0]          cfg_divisor,
   output logic                      busy,
   output logic                      done,
   output logic                      err,
   output logic                      params_ok,
   output logic [WIDTH-1:0]          mult,
   output logic                      sh1,
   output logic [$clog2(WIDTH)-1:0]  sh2
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int SHW = $clog2(WIDTH);
   localparam int LW  = $clog2(WIDTH + 1);
   localparam int CW  = $clog2(WIDTH);

   function automatic logic [LW-1:0] top_bit(input logic [WIDTH-1:0] v);
      logic [LW-1:0] idx;
      idx = '0;
      for (int i = 0; i < WIDTH; i++)
         if (v[i]) idx = LW'(i);
      return idx;
   endfunction

   cfg_state_e        state_q;
   logic [CW-1:0]     cnt_q;
   logic [WIDTH-1:0]  rem_q, quo_q, dsr_q, mult_q;
   logic              sh1_q, done_q, err_q, ok_q;
   logic [SHW-1:0]    sh2_q;

   logic [WIDTH-1:0]  dm1, pow2, r0, rem_d, quo_d;
   logic [LW-1:0]     ceil_l;
   logic [WIDTH:0]    rsh, rdiff;
   logic              ge;

   always_comb begin
      dm1    = cfg_divisor - WIDTH'(1);
      ceil_l = top_bit(dm1) + LW'(1);
      pow2   = (ceil_l == LW'(WIDTH)) ? '0 : (WIDTH'(1) << ceil_l);
      r0     = pow2 - cfg_divisor;
      rsh    = {rem_q, 1'b0};
      ge     = rsh >= {1'b0, dsr_q};
      rdiff  = rsh - {1'b0, dsr_q};
      rem_d  = ge ? rdiff[WIDTH-1:0] : rsh[WIDTH-1:0];
      quo_d  = {quo_q[WIDTH-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CFG_IDLE;
         cnt_q   <= '0;
         rem_q   <= '0;
         quo_q   <= '0;
         dsr_q   <= '0;
         mult_q  <= '0;
         sh1_q   <= 1'b0;
         sh2_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         ok_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            CFG_IDLE: begin
               if (cfg_valid) begin
                  err_q <= 1'b0;
                  ok_q  <= 1'b0;
                  if (cfg_divisor == '0) begin
                     err_q  <= 1'b1;
                     done_q <= 1'b1;
                  end else if (cfg_divisor < WIDTH'(3)) begin
                     mult_q <= WIDTH'(1);
                     sh1_q  <= cfg_divisor[1];
                     sh2_q  <= '0;
                     ok_q   <= 1'b1;
                     done_q <= 1'b1;
                  end else begin
                     state_q <= CFG_CALC;
                     rem_q   <= r0;
                     quo_q   <= '0;
                     dsr_q   <= cfg_divisor;
                     sh1_q   <= 1'b1;
                     sh2_q   <= SHW'(ceil_l - LW'(1));
                     cnt_q   <= '0;
                  end
               end
            end
            CFG_CALC: begin
               rem_q <= rem_d;
               quo_q <= quo_d;
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(WIDTH - 1)) begin
                  state_q <= CFG_IDLE;
                  mult_q  <= quo_d + WIDTH'(1);
                  ok_q    <= 1'b1;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= CFG_IDLE;
         endcase
      end
   end

   assign busy      = (state_q == CFG_CALC);
   assign done      = done_q;
   assign err       = err_q;
   assign params_ok = ok_q;
   assign mult      = mult_q;
   assign sh1       = sh1_q;
   assign sh2       = sh2_q;
endmodule

// File: rtl/recip_pipe.sv
module recip_pipe #(
   parameter int WIDTH = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      enable,
   input  logic [WIDTH-1:0]          mult,
   input  logic                      sh1,
   input  logic [$clog2(WIDTH)-1:0]  sh2,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [WIDTH-1:0]          in_dividend,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [WIDTH-1:0]          out_quotient
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int SHW = $clog2(WIDTH);
   localparam int PW  = 2 * WIDTH;

   logic              v1_q, v2_q, s1_q;
   logic [WIDTH-1:0]  a1_q, t1_q, q2_q;
   logic [SHW-1:0]    s2_q;
   logic [PW-1:0]     prod;
   logic [WIDTH-1:0]  diff, half, sum, q_d;
   logic              adv1, adv2, in_fire;

   always_comb begin
      prod    = {{WIDTH{1'b0}}, mult} * {{WIDTH{1'b0}}, in_dividend};
      adv2    = !v2_q || out_ready;
      adv1    = !v1_q || adv2;
      in_ready = enable && adv1;
      in_fire = in_valid && in_ready;
      diff    = a1_q - t1_q;
      half    = s1_q ? (diff >> 1) : diff;
      sum     = t1_q + half;
      q_d     = sum >> s2_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         v2_q <= 1'b0;
         a1_q <= '0;
         t1_q <= '0;
         s1_q <= 1'b0;
         s2_q <= '0;
         q2_q <= '0;
      end else begin
         if (adv1) begin
            v1_q <= in_fire;
            if (in_fire) begin
               a1_q <= in_dividend;
               t1_q <= prod[PW-1:WIDTH];
               s1_q <= sh1;
               s2_q <= sh2;
            end
         end
         if (adv2) begin
            v2_q <= v1_q;
            if (v1_q) q2_q <= q_d;
         end
      end
   end

   assign out_valid    = v2_q;
   assign out_quotient = q2_q;
endmodule

// File: rtl/recip_divider.sv
module recip_divider #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic [WIDTH-1:0] cfg_divisor,
   output logic             cfg_busy,
   output logic             cfg_done,
   output logic             cfg_err,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_dividend,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_quotient
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int SHW = $clog2(WIDTH);

   generate
      if (WIDTH < 4 || WIDTH > 64) begin : g_width_bad
         $error("recip_divider: WIDTH must lie in 4..64");
      end
   endgenerate

   logic             params_ok, sh1;
   logic [WIDTH-1:0] mult;
   logic [SHW-1:0]   sh2;

   recip_param_gen #(.WIDTH(WIDTH)) u_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_valid   (cfg_valid),
      .cfg_divisor (cfg_divisor),
      .busy        (cfg_busy),
      .done        (cfg_done),
      .err         (cfg_err),
      .params_ok   (params_ok),
      .mult        (mult),
      .sh1         (sh1),
      .sh2         (sh2)
   );

   recip_pipe #(.WIDTH(WIDTH)) u_pipe (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (params_ok),
      .mult         (mult),
      .sh1          (sh1),
      .sh2          (sh2),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_dividend  (in_dividend),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_quotient (out_quotient)
   );
endmodule

// File: rtl/recip_divider_chk.sv
module recip_divider_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_busy,
   input logic             cfg_done,
   input logic             cfg_err,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [WIDTH-1:0] out_quotient
);
   timeunit 1ns;
   timeprecision 1ps;

   // R2
   busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_busy |-> !in_ready);

   // R2
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> !cfg_busy);

   // R6
   err_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !in_ready);

   // R7
   two_stage_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> ##1 out_valid);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_quotient)));
endmodule

bind recip_divider recip_divider_chk #(.WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_busy     (cfg_busy),
   .cfg_done     (cfg_done),
   .cfg_err      (cfg_err),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_quotient (out_quotient)
);

// File: tb/recip_divider_test.sv
module recip_divider_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int WIDTH = 16;
   localparam int NVEC  = 21;
   // {divisor, dividend}
   localparam logic [31:0] VEC [0:NVEC-1] = '{
      {16'd1,     16'd0},     {16'd1,     16'd65535}, {16'd1,     16'd12345},
      {16'd2,     16'd0},     {16'd2,     16'd65535}, {16'd2,     16'd7},
      {16'd3,     16'd65535}, {16'd3,     16'd100},   {16'd7,     16'd0},
      {16'd10,    16'd12345}, {16'd16,    16'd65535}, {16'd255,   16'd256},
      {16'd641,   16'd65535}, {16'd1000,  16'd999},   {16'd1024,  16'd5000},
      {16'd28272, 16'd50000}, {16'd32768, 16'd65535}, {16'd32768, 16'd32767},
      {16'd40000, 16'd65535}, {16'd65535, 16'd65535}, {16'd65535, 16'd65534}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_valid = 1'b0;
   logic [WIDTH-1:0] cfg_divisor = '0;
   logic             cfg_busy, cfg_done, cfg_err;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [WIDTH-1:0] in_dividend = '0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [WIDTH-1:0] out_quotient;

   int    checks = 0;
   int    fails  = 0;
   int    cur_d  = 1;
   int    expq[$];
   string tagq[$];

   always #2.5 clk = !clk;

   recip_divider #(.WIDTH(WIDTH)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_divisor(cfg_divisor),
      .cfg_busy(cfg_busy), .cfg_done(cfg_done), .cfg_err(cfg_err),
      .in_valid(in_valid), .in_ready(in_ready), .in_dividend(in_dividend),
      .out_valid(out_valid), .out_ready(out_ready), .out_quotient(out_quotient)
   );

   task automatic check(input bit ok, input string tag, input int got, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic string tag_for(input int d);
      if (d == 1) return "R3";
      if (d == 2) return "R4";
      return "R5";
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (in_valid && in_ready) begin
            expq.push_back(int'(in_dividend) / cur_d);
            tagq.push_back(tag_for(cur_d));
         end
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               check(1'b0, "R7 spurious output", int'(out_quotient), -1);
            end else begin
               int    e;
               string t;
               e = expq.pop_front();
               t = tagq.pop_front();
               check(int'(out_quotient) == e, t, int'(out_quotient), e);
            end
         end
      end
   end

   task automatic configure(input int d);
      int nbusy;
      bit seen;
      bit rdy_bad;
      nbusy = 0; seen = 1'b0; rdy_bad = 1'b0;
      @(posedge clk); #1 cfg_valid = 1'b1; cfg_divisor = WIDTH'(d);
      @(posedge clk); #1 cfg_valid = 1'b0;
      for (int i = 0; i < 200 && !seen; i++) begin
         @(negedge clk);
         if (cfg_busy) begin
            nbusy++;
            if (in_ready) rdy_bad = 1'b1;
         end
         if (cfg_done) seen = 1'b1;
      end
      cur_d = d;
      if (d >= 3) check(seen && !rdy_bad && nbusy == WIDTH, "R2 busy cycles", nbusy, WIDTH);
      else        check(seen && nbusy == 0, "R2 short setup", nbusy, 0);
   endtask

   task automatic send(input int a, input bit hold);
      @(posedge clk); #1 in_valid = 1'b1; in_dividend = WIDTH'(a);
      do @(negedge clk); while (!in_ready);
      if (!hold) begin
         @(posedge clk); #1 in_valid = 1'b0;
      end
   endtask

   task automatic drain();
      for (int i = 0; i < 100 && expq.size() != 0; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      #(5 * 100000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(!cfg_busy && !cfg_done && !cfg_err && !out_valid && !in_ready, "R1 reset state",
            {cfg_busy, cfg_done, cfg_err, out_valid, in_ready}, 0);

      // R7: two-edge latency
      configure(7);
      send(100, 1'b0);
      @(negedge clk);
      check(!out_valid, "R7 early output", int'(out_valid), 0);
      @(negedge clk);
      check(out_valid && out_quotient == 16'd14, "R7 latency", int'(out_quotient), 14);
      drain();

      // R3 R4 R5: vector table
      for (int i = 0; i < NVEC; i++) begin
         int d;
         int a;
         d = int'(VEC[i][31:16]);
         a = int'(VEC[i][15:0]);
         if (d != cur_d) begin
            drain();
            configure(d);
         end
         send(a, 1'b0);
      end
      drain();

      // R5 R7: back-to-back stream, order preserved
      configure(10);
      for (int i = 0; i < 12; i++) send(i * 5431, i != 11);
      drain();

      // R8: stall holds output
      @(posedge clk); #1 out_ready = 1'b0;
      send(500, 1'b1);
      send(777, 1'b0);
      begin
         bit held;
         held = 1'b1;
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!out_valid || out_quotient != 16'd50) held = 1'b0;
         end
         check(held, "R8 stall hold", int'(out_quotient), 50);
      end
      @(posedge clk); #1 out_ready = 1'b1;
      drain();

      // R9: request during busy is ignored
      begin
         bit seen;
         bit again;
         seen = 1'b0; again = 1'b0;
         @(posedge clk); #1 cfg_valid = 1'b1; cfg_divisor = 16'd9;
         @(posedge clk); #1 cfg_valid = 1'b0;
         repeat (3) @(posedge clk);
         #1 cfg_valid = 1'b1; cfg_divisor = 16'd3;
         @(posedge clk); #1 cfg_valid = 1'b0;
         for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (cfg_done) seen = 1'b1;
         end
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (cfg_busy || cfg_done) again = 1'b1;
         end
         check(seen && !again, "R9 no second setup", int'(again), 0);
         cur_d = 9;
         send(1000, 1'b0);
         drain();
      end

      // R6: zero divisor
      configure(0);
      @(negedge clk);
      check(cfg_err && !in_ready, "R6 error flag", {cfg_err, in_ready}, 2);
      @(posedge clk); #1 in_valid = 1'b1; in_dividend = 16'd1234;
      begin
         bit leak;
         leak = 1'b0;
         for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (in_ready || out_valid) leak = 1'b1;
         end
         check(!leak, "R6 input blocked", int'(leak), 0);
      end
      @(posedge clk); #1 in_valid = 1'b0;
      configure(5);
      @(negedge clk);
      check(!cfg_err && in_ready, "R6 error cleared", {cfg_err, in_ready}, 1);
      send(14, 1'b0);
      drain();
      check(expq.size() == 0, "R7 all outputs returned", expq.size(), 0);

      finish_run();
   end
endmodule